// File: doc/BRIEF.md
# Clock Selector Control Bank

This block is the software-facing control bank for a group of gated clock selectors. Every selector owns one configuration word that holds a select field and a gate bit. Two alias addresses sit beside each word. One sets the bits written as one and the other clears them. Software can therefore change single bits without a read-modify-write sequence that another agent could interrupt. The block drives a select code and a gate-enable towards the clock multiplexing cells, which live outside it.

A select field written through the port is staged first. For selectors that own a bit in the shared update register, the staged code reaches the select output only when software writes a one to that bit. The usual change sequence is three writes: the full field mask to the clear alias, the new index to the set alias, and then the update strobe. Software leaves out all three writes when the selection would not change. During that sequence the field passes through zero, and the select output does not follow it. A selector without an update bit drives its staged code straight to its output. Gate bits never wait for a strobe.

The register port is synchronous and takes one cycle per access. It has a word address, a write enable and 32-bit write data. Read data is registered.

Top module: `clk_sel_bank`

## Requirements
- R1: After reset every staged select field and every select output is 0, and every gate bit is 1, so `gate_en_o` is all zero.
- R2: The port uses word addresses. Selector i has its configuration word at 4*i, its set alias at 4*i+1 and its clear alias at 4*i+2. The update register is at 16. In selector i's word, the select field occupies bits [8*i+1:8*i] and the gate bit is bit 8*i+7. All other bits read as 0, and writes to them are ignored.
- R3: A write to a set alias turns on exactly the field and gate bits written as 1. Bits written as 0 keep their stored value.
- R4: A write to a clear alias turns off exactly the field and gate bits written as 1. Bits written as 0 keep their stored value.
- R5: A write to a configuration word replaces both its select field and its gate bit with the written values.
- R6: Selectors 0 to 2 own update bits 0 to 2. The select output of such a selector holds its value through any staged change. The staged code appears on the output in the cycle after a write to the update register with that selector's bit set.
- R7: Selector 3 has no update bit. Its select output shows its staged field from the cycle after the write that changed it.
- R8: `gate_en_o[i]` is the inverse of selector i's gate bit. It changes in the cycle after the write that changed the gate bit, with no update strobe.
- R9: Update register bits act only when written as 1 and always read back as 0. Bits written as 0, and bits above bit 2, have no effect on any output.
- R10: `rdata_o` is registered. In the cycle after an address is presented it shows the addressed word as it stood before any write in that same cycle. The set and clear aliases read back the configuration word. Address offsets 4*i+3 and every address from 17 upward read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Word address |
| we_i | input | 1 | Write enable for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| sel_o | output | 8 | Select codes, 2 bits per selector, selector 0 in the low bits |
| gate_en_o | output | 4 | Clock enable per selector, 1 means running |

## Verification
If a staged field is corrupted, it shows on the next read of any of that selector's three addresses, one cycle after the address is presented. For selector 3 it also shows on `sel_o` in the cycle after the bad write. For an updated selector, a wrong active register shows on `sel_o` right away if it moves while the staged field goes through zero. A wrong commit shows on `sel_o` in the cycle after the strobe. An error in the alias decode or the gate logic changes `gate_en_o` or read data one cycle after the write, so every transition between every pair of codes on every selector is checked at the ports one cycle after each write.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
  localparam int DATA_W = 32;

  // field placement inside a selector's own word
  function automatic int sel_lsb(int idx, int stride);
    return (idx * stride) % DATA_W;
  endfunction

  function automatic int gate_pos(int idx, int stride);
    return ((idx * stride) % DATA_W) + stride - 1;
  endfunction

  // last selector commits immediately; others own update bit idx
  function automatic int upd_pos(int idx, int n_sel);
    return (idx < n_sel - 1) ? idx : -1;
  endfunction
endpackage

// File: rtl/clk_sel_dec.sv
module clk_sel_dec #(
  parameter int N_SEL  = 4,
  parameter int ADDR_W = 6,
  localparam int IDX_W  = (N_SEL > 1) ? $clog2(N_SEL) : 1,
  localparam int SLOT_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic [N_SEL-1:0]  cfg_we_o,
  output logic [N_SEL-1:0]  set_we_o,
  output logic [N_SEL-1:0]  clr_we_o,
  output logic              upd_we_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              rd_hit_o
);
  localparam int UPD_ADDR = 4 * N_SEL;

  logic [SLOT_W-1:0] slot;
  logic [1:0]        sub;
  logic              in_range;

  assign slot     = addr_i[ADDR_W-1:2];
  assign sub      = addr_i[1:0];
  assign in_range = slot < SLOT_W'(N_SEL);

  for (genvar i = 0; i < N_SEL; i++) begin : g_dec
    logic hit;
    assign hit         = we_i && (slot == SLOT_W'(i));
    assign cfg_we_o[i] = hit && (sub == 2'd0);
    assign set_we_o[i] = hit && (sub == 2'd1);
    assign clr_we_o[i] = hit && (sub == 2'd2);
  end

  assign upd_we_o = we_i && (addr_i == ADDR_W'(UPD_ADDR));
  assign rd_hit_o = in_range && (sub != 2'd3);
  assign rd_idx_o = slot[IDX_W-1:0];
endmodule

// File: rtl/clk_sel_slot.sv
module clk_sel_slot #(
  parameter int SEL_W    = 2,
  parameter int SEL_LSB  = 0,
  parameter int GATE_POS = 7,
  parameter bit HAS_UPD  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [SEL_W-1:0] field_i,
  input  logic             gate_i,
  input  logic             upd_i,
  output logic [31:0]      word_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             gate_en_o
);
  logic [SEL_W-1:0] stg_q, stg_d;
  logic             gate_q, gate_d;

  always_comb begin
    stg_d  = stg_q;
    gate_d = gate_q;
    if (cfg_we_i) begin
      stg_d  = field_i;
      gate_d = gate_i;
    end else if (set_we_i) begin
      stg_d  = stg_q | field_i;
      gate_d = gate_q | gate_i;
    end else if (clr_we_i) begin
      stg_d  = stg_q & ~field_i;
      gate_d = gate_q & ~gate_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      gate_q <= 1'b1;
    end else begin
      stg_q  <= stg_d;
      gate_q <= gate_d;
    end
  end

  if (HAS_UPD) begin : g_upd
    logic [SEL_W-1:0] act_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    act_q <= '0;
      else if (upd_i) act_q <= stg_q;
    end
    assign sel_o = act_q;
  end else begin : g_direct
    assign sel_o = stg_q;
  end

  always_comb begin
    word_o                     = '0;
    word_o[SEL_LSB +: SEL_W]   = stg_q;
    word_o[GATE_POS]           = gate_q;
  end

  assign gate_en_o = ~gate_q;
endmodule

// File: rtl/clk_sel_rd.sv
module clk_sel_rd #(
  parameter int N_SEL  = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_SEL-1:0][DATA_W-1:0] words_i,
  input  logic [IDX_W-1:0]             rd_idx_i,
  input  logic                         rd_hit_i,
  output logic [DATA_W-1:0]            rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_o <= '0;
    else if (rd_hit_i) rdata_o <= words_i[rd_idx_i];
    else               rdata_o <= '0;
  end
endmodule

// File: rtl/clk_sel_bank.sv
module clk_sel_bank
  import clk_sel_pkg::*;
#(
  parameter int N_SEL  = 4,
  parameter int SEL_W  = 2,
  parameter int STRIDE = 8,
  parameter int ADDR_W = 6,
  localparam int IDX_W = (N_SEL > 1) ? $clog2(N_SEL) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   we_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [N_SEL*SEL_W-1:0] sel_o,
  output logic [N_SEL-1:0]       gate_en_o
);
  logic [N_SEL-1:0]             cfg_we, set_we, clr_we;
  logic                         upd_we;
  logic [IDX_W-1:0]             rd_idx;
  logic                         rd_hit;
  logic [N_SEL-1:0][DATA_W-1:0] words;

  clk_sel_dec #(.N_SEL(N_SEL), .ADDR_W(ADDR_W)) dec_i (
    .addr_i   (addr_i),
    .we_i     (we_i),
    .cfg_we_o (cfg_we),
    .set_we_o (set_we),
    .clr_we_o (clr_we),
    .upd_we_o (upd_we),
    .rd_idx_o (rd_idx),
    .rd_hit_o (rd_hit)
  );

  for (genvar i = 0; i < N_SEL; i++) begin : g_slot
    localparam int LSB  = sel_lsb(i, STRIDE);
    localparam int GPOS = gate_pos(i, STRIDE);
    localparam int UPOS = upd_pos(i, N_SEL);
    logic upd;

    if (UPOS >= 0) begin : g_has
      assign upd = upd_we && wdata_i[UPOS];
    end else begin : g_none
      assign upd = 1'b0;
    end

    clk_sel_slot #(
      .SEL_W    (SEL_W),
      .SEL_LSB  (LSB),
      .GATE_POS (GPOS),
      .HAS_UPD  (UPOS >= 0)
    ) slot_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_we_i  (cfg_we[i]),
      .set_we_i  (set_we[i]),
      .clr_we_i  (clr_we[i]),
      .field_i   (wdata_i[LSB +: SEL_W]),
      .gate_i    (wdata_i[GPOS]),
      .upd_i     (upd),
      .word_o    (words[i]),
      .sel_o     (sel_o[i*SEL_W +: SEL_W]),
      .gate_en_o (gate_en_o[i])
    );
  end

  clk_sel_rd #(.N_SEL(N_SEL), .DATA_W(DATA_W), .IDX_W(IDX_W)) rd_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .words_i  (words),
    .rd_idx_i (rd_idx),
    .rd_hit_i (rd_hit),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/clk_sel_bank_chk.sv
module clk_sel_bank_chk
  import clk_sel_pkg::*;
#(
  parameter int N_SEL  = 4,
  parameter int SEL_W  = 2,
  parameter int STRIDE = 8,
  parameter int ADDR_W = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [ADDR_W-1:0]      addr_i,
  input logic                   we_i,
  input logic [DATA_W-1:0]      wdata_i,
  input logic [DATA_W-1:0]      rdata_o,
  input logic [N_SEL*SEL_W-1:0] sel_o,
  input logic [N_SEL-1:0]       gate_en_o
);
  localparam int UPD_ADDR = 4 * N_SEL;

  assert_upd_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(UPD_ADDR)) |=> (rdata_o == '0));

  assert_hole_reads_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[1:0] == 2'd3) |=> (rdata_o == '0));

  for (genvar i = 0; i < N_SEL; i++) begin : g_chk
    localparam int LSB  = sel_lsb(i, STRIDE);
    localparam int GPOS = gate_pos(i, STRIDE);
    localparam int UPOS = upd_pos(i, N_SEL);

    assert_gate_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(4*i+2) && wdata_i[GPOS]) |=> gate_en_o[i]);

    assert_gate_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(4*i+1) && wdata_i[GPOS]) |=> !gate_en_o[i]);

    if (UPOS >= 0) begin : g_staged
      assert_hold_active_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(we_i && addr_i == ADDR_W'(UPD_ADDR) && wdata_i[UPOS])
        |=> $stable(sel_o[i*SEL_W +: SEL_W]));
    end else begin : g_direct
      assert_direct_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == ADDR_W'(4*i+1))
        |=> ((sel_o[i*SEL_W +: SEL_W] & $past(wdata_i[LSB +: SEL_W]))
             == $past(wdata_i[LSB +: SEL_W])));
    end
  end
endmodule

bind clk_sel_bank clk_sel_bank_chk #(
  .N_SEL(N_SEL), .SEL_W(SEL_W), .STRIDE(STRIDE), .ADDR_W(ADDR_W)
) chk_i (.*);

// File: tb/clk_sel_bank_tb_top.sv
module clk_sel_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  sel_o;
  logic [3:0]  gate_en_o;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  int stg [NS];
  int gt  [NS];
  int act [NS];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  clk_sel_bank dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .sel_o(sel_o), .gate_en_o(gate_en_o)
  );

  function automatic logic [31:0] model_word(int a);
    logic [31:0] w;
    int i;
    w = '0;
    if (a < 16 && (a % 4) != 3) begin
      i = a / 4;
      w = (32'(stg[i]) << (8*i)) | (32'(gt[i]) << (8*i + 7));
    end
    return w;
  endfunction

  function automatic logic [7:0] model_sel();
    logic [7:0] s;
    for (int i = 0; i < NS; i++) s[2*i +: 2] = (i == 3) ? 2'(stg[i]) : 2'(act[i]);
    return s;
  endfunction

  function automatic logic [3:0] model_gate();
    logic [3:0] g;
    for (int i = 0; i < NS; i++) g[i] = (gt[i] == 0);
    return g;
  endfunction

  task automatic model_apply(bit we, int a, logic [31:0] d);
    int i, f, gb;
    if (!we) return;
    if (a == 16) begin
      for (int k = 0; k < 3; k++) if (d[k]) act[k] = stg[k];
      return;
    end
    if (a >= 16 || (a % 4) == 3) return;
    i  = a / 4;
    f  = int'(d[8*i +: 2]);
    gb = int'(d[8*i + 7]);
    case (a % 4)
      0: begin stg[i] = f; gt[i] = gb; end
      1: begin stg[i] = stg[i] | f; gt[i] = gt[i] | gb; end
      default: begin stg[i] = stg[i] & ~f & 3; gt[i] = gt[i] & ~gb & 1; end
    endcase
  endtask

  task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with outputs checked
  task automatic cyc(bit we, int a, logic [31:0] d, string tag);
    logic [31:0] exp_rd;
    exp_rd  = model_word(a);
    we_i    = we;
    addr_i  = 6'(a);
    wdata_i = d;
    @(posedge clk_i);
    model_apply(we, a, d);
    @(negedge clk_i);
    we_i = 1'b0;
    check(rdata_o == exp_rd, {tag, " R10 rdata"}, rdata_o, exp_rd);
    check(sel_o == model_sel(), {tag, " sel_o"}, 32'(sel_o), 32'(model_sel()));
    check(gate_en_o == model_gate(), {tag, " R8 gate_en_o"}, 32'(gate_en_o), 32'(model_gate()));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog R1 got=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin stg[i] = 0; gt[i] = 1; act[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset state
    check(sel_o == 8'h00, "R1 sel_o", 32'(sel_o), 0);
    check(gate_en_o == 4'h0, "R1 gate_en_o", 32'(gate_en_o), 0);
    for (int a = 0; a < 64; a++) cyc(1'b0, a, 32'h0, "R1 R2 reset read");

    // R4/R8: enable each gate through clear alias, others untouched
    for (int i = 0; i < NS; i++) cyc(1'b1, 4*i+2, 32'h1 << (8*i+7), "R4 gate clear");
    // R3: gate off and on again
    cyc(1'b1, 1, 32'h80, "R3 gate set");
    cyc(1'b1, 2, 32'h80, "R4 gate clear");

    // R6/R7/R9: every transition on every selector via clear/set/update
    for (int i = 0; i < NS; i++) begin
      for (int o = 0; o < 4; o++) begin
        for (int n = 0; n < 4; n++) begin
          cyc(1'b1, 4*i+2, 32'h3 << (8*i), "R4 R6 prep clear");
          cyc(1'b1, 4*i+1, 32'(o) << (8*i), "R3 prep set");
          cyc(1'b1, 16, 32'h1 << i, "R6 prep update");
          if (o != n) begin
            cyc(1'b1, 4*i+2, 32'h3 << (8*i), "R4 R6 R7 clear mask");
            cyc(1'b0, 4*i+1, 32'h0, "R10 set alias read");
            cyc(1'b1, 4*i+1, 32'(n) << (8*i), "R3 R6 R7 set index");
            cyc(1'b0, 4*i+2, 32'h0, "R10 clear alias read");
            cyc(1'b1, 16, 32'hFFFF_FFF8 | (32'h7 & ~(32'h1 << i)), "R9 other bits");
            cyc(1'b1, 16, 32'h1 << i, "R6 update strobe");
            cyc(1'b0, 4*i, 32'h0, "R10 cfg read");
          end
        end
      end
    end

    // R5: direct configuration write, undefined bits ignored
    for (int i = 0; i < NS; i++) begin
      cyc(1'b1, 4*i, 32'hFFFF_FFFF, "R5 R2 full write");
      cyc(1'b0, 4*i, 32'h0, "R2 R5 readback");
      cyc(1'b1, 4*i, 32'h2 << (8*i), "R5 field only");
      cyc(1'b1, 16, 32'hF, "R6 R9 commit all");
      cyc(1'b0, 4*i, 32'h0, "R5 readback");
    end

    // R9: update register reads zero, zero write has no effect
    cyc(1'b1, 4, 32'h100, "R3 stage sel1");
    cyc(1'b1, 16, 32'h0, "R9 zero write");
    cyc(1'b0, 16, 32'h0, "R9 read update");

    // R10: read during write shows previous word
    cyc(1'b1, 9, 32'h0003_0000, "R10 read before write");
    cyc(1'b0, 9, 32'h0, "R10 read after write");

    // R2: final address sweep
    for (int a = 0; a < 64; a++) cyc(1'b0, a, 32'h0, "R2 sweep");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule